// File: doc/BRIEF.md
# ISA Host Port with Burst Channel

This block sits between an asynchronous ISA-style host bus and an internal controller. The host reaches it through an active-low chip select, active-low read and write strobes, a 3-bit register address and a 16-bit data bus. The controller sees holding registers, register-write pulses and FIFO endpoints, all synchronous to the internal clock.

The address space has three windows. Addresses 00x form a byte-wide port in MIDI-UART style: a data register and a status/control register, each backed by a one-byte holding register per direction. Addresses 01x reach a 16-bit burst data port. It is backed by one FIFO per direction, so the host can stream audio or program words with back-to-back string I/O. Addresses 1xx reach four byte-wide auxiliary registers, used for game-sound emulation.

The host strobes pass through two-flop synchronizers, and each access acts once, on the falling strobe edge. The block drives a combinational 16-bit-cycle indicator for the burst window. It also drives a ready line, which inserts bus wait states only when the burst FIFO cannot take or supply a word, and only up to a fixed limit.

Top module: `isa_host_port`

## Requirements
- R1: A host write to address 000 places the low data byte in the command holding register with `ctl_cmd_is_ctrl`=0; a write to 001 does the same with `ctl_cmd_is_ctrl`=1. A host read of 000 returns the reply byte and empties the reply holding register.
- R2: A host read of 001 returns a status byte on bits 7:0. Bit 7 is 1 when no reply byte is held (the host may not read). Bit 6 is 1 when the command holding register is full (the host may not write). Bit 5 is 1 when the burst write FIFO is full. Bit 4 is 1 when the burst read FIFO holds at least one word. Bits 3:0 are 0.
- R3: A held command byte stays unchanged until `ctl_cmd_ack`, and host writes to 00x made while it is held are dropped. A controller reply write made while a reply byte is held is refused, and `ctl_reply_full` shows that state.
- R4: A host write to 1xx stores the low data byte in auxiliary register addr[1:0] and gives a one-cycle `ctl_aux_wr` pulse carrying that index and byte. A host read of 1xx returns the stored byte. All four registers reset to 0.
- R5: Host writes to 01x push 16-bit words to the controller in arrival order. Controller pushes reach host reads of 01x in arrival order. Each FIFO holds FIFO_DEPTH (16) words.
- R6: `cyc16_n` is low exactly while `hcs_n` is low and haddr[2:1] equals 01, independent of the strobes and of the clock.
- R7: Byte-window reads (00x, 1xx) return 0 on data bits 15:8. Data bits 15:8 of byte-window writes are ignored.
- R8: `host_rdy` stays high through every byte-window access. It also stays high through every burst access whose FIFO can accept (write) or supply (read) a word at once.
- R9: A burst write that finds the write FIFO full holds `host_rdy` low until the controller frees a slot. The word is then stored and `host_rdy` returns high.
- R10: A burst read that finds the read FIFO empty holds `host_rdy` low until the controller pushes a word. That word is then returned and `host_rdy` returns high.
- R11: A wait lasts at most WAIT_MAX (128) clocks. At the limit `host_rdy` returns high: a waiting write word is discarded, and a waiting read returns 16'h0000.
- R12: A controller push into a full read FIFO is refused, and `ctl_bout_full` is high while that FIFO is full.
- R13: Each strobe falling edge triggers exactly one register action. Read data stays on `hdata_out` until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hcs_n | input | 1 | Host chip select, active low |
| hrd_n | input | 1 | Host read strobe, active low |
| hwr_n | input | 1 | Host write strobe, active low |
| haddr | input | 3 | Host register address |
| hdata_in | input | DW | Host write data |
| hdata_out | output | DW | Host read data |
| hdata_oe | output | 1 | Read data drive enable (chip select and read strobe both low) |
| cyc16_n | output | 1 | 16-bit cycle indicator, active low |
| host_rdy | output | 1 | Ready line; low inserts wait states |
| ctl_cmd_valid | output | 1 | Command holding register is full |
| ctl_cmd_data | output | DW/2 | Held command byte |
| ctl_cmd_is_ctrl | output | 1 | Held byte was written at address 001 |
| ctl_cmd_ack | input | 1 | Controller consumed the command byte |
| ctl_reply_wr | input | 1 | Controller writes a reply byte |
| ctl_reply_data | input | DW/2 | Reply byte |
| ctl_reply_full | output | 1 | Reply holding register is full |
| ctl_aux_wr | output | 1 | One-cycle auxiliary write pulse |
| ctl_aux_idx | output | 2 | Auxiliary register index |
| ctl_aux_data | output | DW/2 | Auxiliary byte written |
| ctl_bin_valid | output | 1 | Burst write FIFO holds a word |
| ctl_bin_data | output | DW | Head word of the burst write FIFO |
| ctl_bin_pop | input | 1 | Controller pops the head word |
| ctl_bout_push | input | 1 | Controller pushes a word for host reads |
| ctl_bout_data | input | DW | Word to push |
| ctl_bout_full | output | 1 | Burst read FIFO is full |

## Verification
The bench goes after the wait-state corners. It fills the write FIFO and then frees a slot during a stalled write. It reads an empty FIFO and then pushes a word while the read is stalled. It also lets each kind of stall run to the limit. A design that got these wrong would hang the bus, store a dropped word, or return a word twice. The bench checks that the held command byte survives a second host write. A design that overwrote it would lose commands. It also checks that a refused reply write cannot replace an unread reply. Address-decode corners are covered too: the 16-bit indicator for 011 versus 100, and the upper data lane on byte registers. A wrong decode there would assert the indicator for a byte register or leak stale upper data.

// File: rtl/hp_pkg.sv
package hp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WAIT_WR = 2'd1,
    ST_WAIT_RD = 2'd2
  } hp_state_t;

  typedef enum logic [1:0] {
    SEL_PRI   = 2'd0,
    SEL_BURST = 2'd1,
    SEL_AUX   = 2'd2
  } hp_sel_t;

  // Window decode from the host address: 00x byte pair, 01x burst, 1xx aux.
  function automatic hp_sel_t decode_sel(input logic [2:0] a);
    if (a[2])      return SEL_AUX;
    else if (a[1]) return SEL_BURST;
    else           return SEL_PRI;
  endfunction

endpackage

// File: rtl/hp_sync.sv
module hp_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= {STAGES{RST_VAL}};
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];

endmodule

// File: rtl/hp_fifo.sv
module hp_fifo #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);

  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, wptr_nxt, rptr, rptr_nxt;
  logic [CW-1:0] count, count_nxt;
  logic          push_ok, pop_ok;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign rdata   = mem[rptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    if (p == AW'(DEPTH - 1)) return '0;
    else                     return p + 1'b1;
  endfunction

  always_comb begin
    wptr_nxt  = push_ok ? bump(wptr) : wptr;
    rptr_nxt  = pop_ok  ? bump(rptr) : rptr;
    count_nxt = count;
    if (push_ok && !pop_ok)      count_nxt = count + 1'b1;
    else if (pop_ok && !push_ok) count_nxt = count - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      wptr  <= wptr_nxt;
      rptr  <= rptr_nxt;
      count <= count_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= wdata;
  end

  // R12: a push into a full FIFO leaves the occupancy untouched
  a_r12_full_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> (full && $stable(count)));

  // R5: popping an empty FIFO does not underflow it
  a_r5_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> empty);

endmodule

// File: rtl/isa_host_port.sv
module isa_host_port
  import hp_pkg::*;
#(
  parameter int unsigned DW         = 16,
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned WAIT_MAX   = 128,
  parameter int unsigned SYNC_STG   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hcs_n,
  input  logic            hrd_n,
  input  logic            hwr_n,
  input  logic [2:0]      haddr,
  input  logic [DW-1:0]   hdata_in,
  output logic [DW-1:0]   hdata_out,
  output logic            hdata_oe,
  output logic            cyc16_n,
  output logic            host_rdy,
  output logic            ctl_cmd_valid,
  output logic [DW/2-1:0] ctl_cmd_data,
  output logic            ctl_cmd_is_ctrl,
  input  logic            ctl_cmd_ack,
  input  logic            ctl_reply_wr,
  input  logic [DW/2-1:0] ctl_reply_data,
  output logic            ctl_reply_full,
  output logic            ctl_aux_wr,
  output logic [1:0]      ctl_aux_idx,
  output logic [DW/2-1:0] ctl_aux_data,
  output logic            ctl_bin_valid,
  output logic [DW-1:0]   ctl_bin_data,
  input  logic            ctl_bin_pop,
  input  logic            ctl_bout_push,
  input  logic [DW-1:0]   ctl_bout_data,
  output logic            ctl_bout_full
);

  localparam int unsigned BW    = DW / 2;
  localparam int unsigned WCW   = $clog2(WAIT_MAX + 1);
  localparam int unsigned AUX_N = 4;
  localparam int unsigned NSTB  = 3;

  // ---------------- reset release and strobe synchronizers ----------------
  logic rst_int_n;

  hp_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_int_n));

  logic [NSTB-1:0] stb_raw_n, stb_sync_n;
  assign stb_raw_n = {hcs_n, hrd_n, hwr_n};

  for (genvar g = 0; g < NSTB; g++) begin : g_stb
    hp_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_int_n), .d(stb_raw_n[g]), .q(stb_sync_n[g]));
  end

  logic rd_act, wr_act, rd_act_q, wr_act_q, rd_evt, wr_evt;
  assign rd_act = !stb_sync_n[2] && !stb_sync_n[1];
  assign wr_act = !stb_sync_n[2] && !stb_sync_n[0];
  assign rd_evt = rd_act && !rd_act_q;
  assign wr_evt = wr_act && !wr_act_q;

  // ---------------- state ----------------
  hp_state_t      state, state_nxt;
  hp_sel_t        cur_sel, sel_nxt;
  logic [WCW-1:0] wait_cnt, wait_nxt;
  logic [DW-1:0]  rd_hold, rd_hold_nxt, wr_hold, wr_hold_nxt;
  logic           cmd_v, cmd_v_nxt, cmd_ctrl, cmd_ctrl_nxt;
  logic [BW-1:0]  cmd_data, cmd_data_nxt;
  logic           rep_v, rep_v_nxt;
  logic [BW-1:0]  rep_data, rep_data_nxt;
  logic [BW-1:0]  aux_mem [AUX_N];
  logic [BW-1:0]  aux_nxt [AUX_N];
  logic           aux_wr, aux_wr_nxt;
  logic [1:0]     aux_idx, aux_idx_nxt;
  logic [BW-1:0]  aux_data, aux_data_nxt;

  logic           bin_push, bin_full, bin_empty;
  logic [DW-1:0]  bin_wdata;
  logic           bout_pop, bout_full, bout_empty;
  logic [DW-1:0]  bout_head;
  logic [BW-1:0]  status;
  hp_sel_t        evt_sel;

  assign evt_sel = decode_sel(haddr);
  assign status  = {!rep_v, cmd_v, bin_full, !bout_empty, 4'b0000};

  // ---------------- next-state logic ----------------
  always_comb begin
    state_nxt    = state;
    sel_nxt      = cur_sel;
    wait_nxt     = wait_cnt;
    rd_hold_nxt  = rd_hold;
    wr_hold_nxt  = wr_hold;
    cmd_v_nxt    = cmd_v && !ctl_cmd_ack;
    cmd_data_nxt = cmd_data;
    cmd_ctrl_nxt = cmd_ctrl;
    rep_v_nxt    = rep_v;
    rep_data_nxt = rep_data;
    aux_nxt      = aux_mem;
    aux_wr_nxt   = 1'b0;
    aux_idx_nxt  = aux_idx;
    aux_data_nxt = aux_data;
    bin_push     = 1'b0;
    bin_wdata    = wr_hold;
    bout_pop     = 1'b0;

    if (ctl_reply_wr && !rep_v) begin
      rep_v_nxt    = 1'b1;
      rep_data_nxt = ctl_reply_data;
    end

    case (state)
      ST_IDLE: begin
        if (rd_evt) begin
          sel_nxt = evt_sel;
          case (evt_sel)
            SEL_PRI: begin
              if (haddr[0]) rd_hold_nxt = {{BW{1'b0}}, status};
              else begin
                rd_hold_nxt = {{BW{1'b0}}, rep_data};
                if (rep_v) rep_v_nxt = 1'b0;
              end
            end
            SEL_BURST: begin
              if (!bout_empty) begin
                bout_pop    = 1'b1;
                rd_hold_nxt = bout_head;
              end else begin
                state_nxt = ST_WAIT_RD;
                wait_nxt  = '0;
              end
            end
            default: rd_hold_nxt = {{BW{1'b0}}, aux_mem[haddr[1:0]]};
          endcase
        end else if (wr_evt) begin
          sel_nxt = evt_sel;
          case (evt_sel)
            SEL_PRI: begin
              if (!cmd_v) begin
                cmd_v_nxt    = 1'b1;
                cmd_data_nxt = hdata_in[BW-1:0];
                cmd_ctrl_nxt = haddr[0];
              end
            end
            SEL_BURST: begin
              if (!bin_full) begin
                bin_push  = 1'b1;
                bin_wdata = hdata_in;
              end else begin
                state_nxt   = ST_WAIT_WR;
                wr_hold_nxt = hdata_in;
                wait_nxt    = '0;
              end
            end
            default: begin
              aux_nxt[haddr[1:0]] = hdata_in[BW-1:0];
              aux_wr_nxt          = 1'b1;
              aux_idx_nxt         = haddr[1:0];
              aux_data_nxt        = hdata_in[BW-1:0];
            end
          endcase
        end
      end
      ST_WAIT_WR: begin
        if (!bin_full) begin
          bin_push  = 1'b1;
          state_nxt = ST_IDLE;
        end else if (wait_cnt == WCW'(WAIT_MAX - 1)) begin
          state_nxt = ST_IDLE;
        end else begin
          wait_nxt = wait_cnt + 1'b1;
        end
      end
      ST_WAIT_RD: begin
        if (!bout_empty) begin
          bout_pop    = 1'b1;
          rd_hold_nxt = bout_head;
          state_nxt   = ST_IDLE;
        end else if (wait_cnt == WCW'(WAIT_MAX - 1)) begin
          rd_hold_nxt = '0;
          state_nxt   = ST_IDLE;
        end else begin
          wait_nxt = wait_cnt + 1'b1;
        end
      end
      default: state_nxt = ST_IDLE;
    endcase
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rd_act_q <= 1'b0;
      wr_act_q <= 1'b0;
      state    <= ST_IDLE;
      cur_sel  <= SEL_PRI;
      wait_cnt <= '0;
      rd_hold  <= '0;
      wr_hold  <= '0;
      cmd_v    <= 1'b0;
      cmd_data <= '0;
      cmd_ctrl <= 1'b0;
      rep_v    <= 1'b0;
      rep_data <= '0;
      aux_wr   <= 1'b0;
      aux_idx  <= '0;
      aux_data <= '0;
      for (int i = 0; i < AUX_N; i++) aux_mem[i] <= '0;
    end else begin
      rd_act_q <= rd_act;
      wr_act_q <= wr_act;
      state    <= state_nxt;
      cur_sel  <= sel_nxt;
      wait_cnt <= wait_nxt;
      rd_hold  <= rd_hold_nxt;
      wr_hold  <= wr_hold_nxt;
      cmd_v    <= cmd_v_nxt;
      cmd_data <= cmd_data_nxt;
      cmd_ctrl <= cmd_ctrl_nxt;
      rep_v    <= rep_v_nxt;
      rep_data <= rep_data_nxt;
      aux_wr   <= aux_wr_nxt;
      aux_idx  <= aux_idx_nxt;
      aux_data <= aux_data_nxt;
      for (int i = 0; i < AUX_N; i++) aux_mem[i] <= aux_nxt[i];
    end
  end

  // ---------------- burst FIFOs ----------------
  hp_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_bin (
    .clk(clk), .rst_n(rst_int_n), .push(bin_push), .wdata(bin_wdata),
    .pop(ctl_bin_pop), .rdata(ctl_bin_data), .full(bin_full), .empty(bin_empty));

  hp_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_bout (
    .clk(clk), .rst_n(rst_int_n), .push(ctl_bout_push), .wdata(ctl_bout_data),
    .pop(bout_pop), .rdata(bout_head), .full(bout_full), .empty(bout_empty));

  // ---------------- outputs ----------------
  assign cyc16_n         = !(!hcs_n && (haddr[2:1] == 2'b01));
  assign hdata_out       = rd_hold;
  assign hdata_oe        = !hcs_n && !hrd_n;
  assign host_rdy        = (state == ST_IDLE);
  assign ctl_cmd_valid   = cmd_v;
  assign ctl_cmd_data    = cmd_data;
  assign ctl_cmd_is_ctrl = cmd_ctrl;
  assign ctl_reply_full  = rep_v;
  assign ctl_aux_wr      = aux_wr;
  assign ctl_aux_idx     = aux_idx;
  assign ctl_aux_data    = aux_data;
  assign ctl_bin_valid   = !bin_empty;
  assign ctl_bout_full   = bout_full;

  // ---------------- assertions ----------------
  // R8: wait states only ever come from a burst-window access
  a_r8_wait_burst_only: assert property (@(posedge clk) disable iff (!rst_int_n)
    !host_rdy |-> (cur_sel == SEL_BURST));

  // R11: the last permitted wait cycle always ends the wait
  a_r11_wait_limit: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!host_rdy && wait_cnt == WCW'(WAIT_MAX - 1)) |=> host_rdy);

  // R9: a stalled write finishes as soon as the FIFO has room
  a_r9_release_on_room: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state == ST_WAIT_WR && !bin_full) |=> host_rdy);

  // R10: a stalled read finishes as soon as a word is present
  a_r10_release_on_data: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state == ST_WAIT_RD && !bout_empty) |=> (host_rdy && hdata_out == $past(bout_head)));

  // R3: an unacknowledged command byte is neither lost nor overwritten
  a_r3_cmd_hold: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmd_v && !ctl_cmd_ack) |=> (cmd_v && $stable(cmd_data)));

  // R13: one strobe edge gives at most one auxiliary write pulse
  a_r13_aux_single: assert property (@(posedge clk) disable iff (!rst_int_n)
    aux_wr |=> !aux_wr);

endmodule

// File: tb/isa_host_port_test.sv
module isa_host_port_test;

  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          hcs_n, hrd_n, hwr_n;
  logic [2:0]    haddr;
  logic [DW-1:0] hdata_in, hdata_out;
  logic          hdata_oe, cyc16_n, host_rdy;
  logic          ctl_cmd_valid, ctl_cmd_is_ctrl, ctl_cmd_ack;
  logic [7:0]    ctl_cmd_data, ctl_reply_data, ctl_aux_data;
  logic          ctl_reply_wr, ctl_reply_full, ctl_aux_wr;
  logic [1:0]    ctl_aux_idx;
  logic          ctl_bin_valid, ctl_bin_pop, ctl_bout_push, ctl_bout_full;
  logic [DW-1:0] ctl_bin_data, ctl_bout_data;

  int checks = 0;
  int errors = 0;
  int aux_pulses = 0;
  logic [1:0] aux_last_idx;
  logic [7:0] aux_last_data;

  always #5 clk = ~clk;

  isa_host_port uut (
    .clk(clk), .rst_n(rst_n), .hcs_n(hcs_n), .hrd_n(hrd_n), .hwr_n(hwr_n),
    .haddr(haddr), .hdata_in(hdata_in), .hdata_out(hdata_out), .hdata_oe(hdata_oe),
    .cyc16_n(cyc16_n), .host_rdy(host_rdy),
    .ctl_cmd_valid(ctl_cmd_valid), .ctl_cmd_data(ctl_cmd_data),
    .ctl_cmd_is_ctrl(ctl_cmd_is_ctrl), .ctl_cmd_ack(ctl_cmd_ack),
    .ctl_reply_wr(ctl_reply_wr), .ctl_reply_data(ctl_reply_data),
    .ctl_reply_full(ctl_reply_full), .ctl_aux_wr(ctl_aux_wr),
    .ctl_aux_idx(ctl_aux_idx), .ctl_aux_data(ctl_aux_data),
    .ctl_bin_valid(ctl_bin_valid), .ctl_bin_data(ctl_bin_data), .ctl_bin_pop(ctl_bin_pop),
    .ctl_bout_push(ctl_bout_push), .ctl_bout_data(ctl_bout_data),
    .ctl_bout_full(ctl_bout_full));

  always @(negedge clk) begin
    if (ctl_aux_wr) begin
      aux_pulses++;
      aux_last_idx  = ctl_aux_idx;
      aux_last_data = ctl_aux_data;
    end
  end

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // One host bus cycle; returns read data and the number of wait clocks seen.
  task automatic host_acc(input bit is_wr, input logic [2:0] a, input logic [15:0] d,
                          output logic [15:0] q, output int waited);
    @(negedge clk);
    haddr = a; hdata_in = d; hcs_n = 1'b0;
    if (is_wr) hwr_n = 1'b0; else hrd_n = 1'b0;
    waited = 0;
    repeat (6) begin
      @(negedge clk);
      if (!host_rdy) waited++;
    end
    while (!host_rdy && waited < 2000) begin
      @(negedge clk);
      if (!host_rdy) waited++;
    end
    q = hdata_out;
    hcs_n = 1'b1; hrd_n = 1'b1; hwr_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic hwrite(input logic [2:0] a, input logic [15:0] d, output int waited);
    logic [15:0] q;
    host_acc(1'b1, a, d, q, waited);
  endtask

  task automatic hread(input logic [2:0] a, output logic [15:0] q, output int waited);
    host_acc(1'b0, a, 16'h0000, q, waited);
  endtask

  task automatic ctl_pop(output logic [15:0] q);
    @(negedge clk);
    q = ctl_bin_data;
    ctl_bin_pop = 1'b1;
    @(negedge clk);
    ctl_bin_pop = 1'b0;
  endtask

  task automatic ctl_push(input logic [15:0] d);
    @(negedge clk);
    ctl_bout_data = d; ctl_bout_push = 1'b1;
    @(negedge clk);
    ctl_bout_push = 1'b0;
  endtask

  task automatic ctl_ack();
    @(negedge clk); ctl_cmd_ack = 1'b1;
    @(negedge clk); ctl_cmd_ack = 1'b0;
  endtask

  task automatic ctl_reply(input logic [7:0] d);
    @(negedge clk); ctl_reply_data = d; ctl_reply_wr = 1'b1;
    @(negedge clk); ctl_reply_wr = 1'b0;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    logic [15:0] q; int w;
    check("reset host_rdy R8", host_rdy, 1);
    check("reset cyc16_n R6", cyc16_n, 1);
    check("reset cmd valid R1", ctl_cmd_valid, 0);
    check("reset bin valid R5", ctl_bin_valid, 0);
    hread(3'b001, q, w);
    check("reset status R2", q, 16'h0080);
  endtask

  task automatic t_primary();
    logic [15:0] q; int w;
    hwrite(3'b000, 16'h01A5, w);
    check("data write valid R1", ctl_cmd_valid, 1);
    check("data write byte R7", ctl_cmd_data, 8'hA5);
    check("data write tag R1", ctl_cmd_is_ctrl, 0);
    check("byte write no wait R8", w, 0);
    hread(3'b001, q, w);
    check("status cmd full R2", q, 16'h00C0);
    hwrite(3'b000, 16'h003C, w);
    check("held byte kept R3", ctl_cmd_data, 8'hA5);
    ctl_ack();
    check("ack clears R3", ctl_cmd_valid, 0);
    hwrite(3'b001, 16'h003F, w);
    check("ctrl write tag R1", ctl_cmd_is_ctrl, 1);
    check("ctrl write byte R1", ctl_cmd_data, 8'h3F);
    ctl_ack();
    ctl_reply(8'h77);
    check("reply full R3", ctl_reply_full, 1);
    hread(3'b001, q, w);
    check("status reply held R2", q, 16'h0000);
    ctl_reply(8'h88);
    hread(3'b000, q, w);
    check("reply read R1", q, 16'h0077);
    check("reply read no wait R8", w, 0);
    check("reply emptied R1", ctl_reply_full, 0);
    hread(3'b001, q, w);
    check("status after reply read R2", q, 16'h0080);
  endtask

  task automatic t_aux();
    logic [15:0] q; int w; int p0;
    p0 = aux_pulses;
    hwrite(3'b101, 16'hFF12, w);
    check("aux pulse count R4", aux_pulses - p0, 1);
    check("aux pulse idx R4", aux_last_idx, 2'd1);
    check("aux pulse data R4", aux_last_data, 8'h12);
    hwrite(3'b111, 16'h009A, w);
    hread(3'b101, q, w);
    check("aux read upper zero R7", q, 16'h0012);
    hread(3'b100, q, w);
    check("aux untouched R4", q, 16'h0000);
    hread(3'b111, q, w);
    check("aux read back R4", q, 16'h009A);
    check("aux edges one pulse each R13", aux_pulses - p0, 2);
  endtask

  task automatic t_cyc16();
    @(negedge clk);
    hcs_n = 1'b0; haddr = 3'b010; #1;
    check("cyc16 addr 010 R6", cyc16_n, 0);
    haddr = 3'b011; #1;
    check("cyc16 addr 011 R6", cyc16_n, 0);
    haddr = 3'b100; #1;
    check("cyc16 addr 100 R6", cyc16_n, 1);
    haddr = 3'b001; #1;
    check("cyc16 addr 001 R6", cyc16_n, 1);
    hcs_n = 1'b1; haddr = 3'b010; #1;
    check("cyc16 deselected R6", cyc16_n, 1);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_burst_basic();
    logic [15:0] q; int w;
    hwrite(3'b010, 16'h1234, w);
    check("burst write no wait R8", w, 0);
    hwrite(3'b011, 16'hABCD, w);
    hwrite(3'b010, 16'h0F0F, w);
    ctl_pop(q); check("burst in order 0 R5", q, 16'h1234);
    ctl_pop(q); check("burst in order 1 R5", q, 16'hABCD);
    ctl_pop(q); check("burst in order 2 R5", q, 16'h0F0F);
    check("burst in drained R5", ctl_bin_valid, 0);
    ctl_push(16'h5A5A);
    ctl_push(16'hC3C3);
    hread(3'b010, q, w);
    check("burst out order 0 R5", q, 16'h5A5A);
    check("burst read no wait R8", w, 0);
    hread(3'b011, q, w);
    check("burst out order 1 R5", q, 16'hC3C3);
  endtask

  task automatic t_full_wait();
    logic [15:0] q; int w;
    for (int i = 0; i < 16; i++) hwrite(3'b010, 16'h1000 + 16'(i), w);
    hread(3'b001, q, w);
    check("status write fifo full R2", q, 16'h00A0);
    fork
      hwrite(3'b010, 16'h1010, w);
      begin
        repeat (25) @(negedge clk);
        ctl_pop(q);
      end
    join
    check("stall popped head R9", q, 16'h1000);
    check("write stalled R9", (w > 5 && w < 60), 1);
    for (int i = 1; i <= 16; i++) begin
      ctl_pop(q);
      check("stalled write order R9", q, 16'h1000 + 16'(i));
    end
    check("drained after stall R9", ctl_bin_valid, 0);
  endtask

  task automatic t_write_timeout();
    logic [15:0] q; int w;
    for (int i = 0; i < 16; i++) hwrite(3'b010, 16'h2000 + 16'(i), w);
    hwrite(3'b010, 16'hDEAD, w);
    check("write wait bounded R11", (w >= 110 && w <= 140), 1);
    check("ready back after limit R11", host_rdy, 1);
    for (int i = 0; i < 16; i++) begin
      ctl_pop(q);
      check("timeout keeps old words R11", q, 16'h2000 + 16'(i));
    end
    check("timed-out word dropped R11", ctl_bin_valid, 0);
  endtask

  task automatic t_read_wait();
    logic [15:0] q; int w;
    fork
      hread(3'b010, q, w);
      begin
        repeat (30) @(negedge clk);
        ctl_push(16'hBEEF);
      end
    join
    check("stalled read data R10", q, 16'hBEEF);
    check("read stalled R10", (w > 5 && w < 60), 1);
    hread(3'b010, q, w);
    check("read timeout data R11", q, 16'h0000);
    check("read wait bounded R11", (w >= 110 && w <= 140), 1);
  endtask

  task automatic t_out_full();
    logic [15:0] q; int w;
    for (int i = 0; i < 17; i++) ctl_push(16'h3000 + 16'(i));
    check("read fifo full flag R12", ctl_bout_full, 1);
    hread(3'b001, q, w);
    check("status read data ready R2", q, 16'h0090);
    for (int i = 0; i < 16; i++) begin
      hread(3'b010, q, w);
      check("read fifo order R12", q, 16'h3000 + 16'(i));
    end
    check("read fifo not full R12", ctl_bout_full, 0);
    hread(3'b001, q, w);
    check("refused push absent R12", q, 16'h0080);
    hread(3'b010, q, w);
    check("stale data held R13", (w > 0), 1);
    check("held data after timeout R13", hdata_out, 16'h0000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    hcs_n = 1'b1; hrd_n = 1'b1; hwr_n = 1'b1;
    haddr = 3'b000; hdata_in = '0;
    ctl_cmd_ack = 1'b0; ctl_reply_wr = 1'b0; ctl_reply_data = '0;
    ctl_bin_pop = 1'b0; ctl_bout_push = 1'b0; ctl_bout_data = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_primary();
    t_aux();
    t_cyc16();
    t_burst_basic();
    t_full_wait();
    t_write_timeout();
    t_read_wait();
    t_out_full();
    summary();
    $finish;
  end

endmodule